// File: doc/BRIEF.md
# Peripheral access protection gate

This block stands between a single register-bus master and a bank of peripheral slots. Every access carries a privilege qualifier and an address. The address holds a one-bit secure-path selector, a 6-bit peripheral ID and a register offset. The gate compares the access with two per-peripheral attribute vectors. The first marks a peripheral as privileged-only. The second marks it as secure, which means it may be reached only through the secure path.

An access that breaks either rule is swallowed. The peripheral never sees it, a read returns zero and a write is discarded. A flag is raised for the kind of violation, and the ID of the peripheral is kept in a fault-status register. A global enable switches the whole check off. While it is off, every access passes.

A small configuration port holds the enable, the attribute vectors, the flag and interrupt-enable registers with mask-based set and clear, the pending view and the fault ID. Two interrupt lines report privilege and secure-path faults.

The sequencing is a three-state machine:
- **IDLE**: waits for a request.
- **IDLE→PASS**: taken when a request is accepted and allowed.
- **IDLE→DROP**: taken when a request is accepted and violates a rule.
- **PASS**: forwards the access to the slot and completes it.
- **DROP**: completes the access with zero data and reports the fault.
- **PASS→IDLE** and **DROP→IDLE**: both are unconditional.

Top module: `periph_guard`

## Requirements
- R1: After reset, the enable, both attribute vectors, the flags, the interrupt enables and the fault ID read as zero, and both interrupt lines and `m_busy` are low.
- R2: With the enable (register 0x0, bit 0) clear, every access is forwarded to the slot with its ID, offset, write flag and write data unchanged, read data is returned, and no flag is set.
- R3: With the enable set, an access with `m_priv` low to a peripheral whose privileged-only bit is set never asserts `s_valid`. A read returns zero. The same access with `m_priv` high is forwarded.
- R4: A privilege violation sets flag bit 0 and loads the fault ID register with the accessed peripheral's ID.
- R5: With the enable set, an access whose secure-path bit (`m_addr` MSB) differs from the target's secure attribute is blocked, sets flag bit 1 and records the ID. A secure peripheral reached with the MSB set, or a non-secure one reached with it clear, is forwarded.
- R6: While any flag is set, the fault ID register keeps its value. The next fault after all flags are cleared loads the new ID.
- R7: The configuration registers are laid out as follows. Flag bit 0 is the privilege fault and bit 1 is the secure fault.
  - 0x0: control.
  - 0x1 and 0x2: privileged-only attributes for IDs 0–31 and 32–63.
  - 0x3 and 0x4: secure attributes for IDs 0–31 and 32–63.
  - 0x5: flags.
  - 0x6: flag-set mask.
  - 0x7: flag-clear mask.
  - 0x8: interrupt enables.
  - 0x9: enable-set mask.
  - 0xA: enable-clear mask.
  - 0xB: pending.
  - 0xC: fault ID.
- R8: Pending (0xB) reads as flags AND enables, and reading it or the flags leaves the flags unchanged.
- R9: Each interrupt line is high exactly while its flag and its enable are both set. Setting the enable of an already pending flag raises the line.
- R10: A hardware fault in the same cycle as a software clear of the same flag leaves the flag set.
- R11: A request seen while `m_busy` is low completes with `m_done` in the following cycle, during which `m_busy` is high. A request while `m_busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_req | input | 1 | Master request strobe |
| m_write | input | 1 | Master write (1) or read (0) |
| m_priv | input | 1 | Master access is privileged |
| m_addr | input | 15 | {secure-path bit, peripheral ID[5:0], offset[7:0]} |
| m_wdata | input | 32 | Master write data |
| m_busy | output | 1 | Gate is completing an access |
| m_done | output | 1 | Access completed this cycle |
| m_rdata | output | 32 | Read data, zero for blocked accesses and writes |
| s_valid | output | 1 | Access forwarded to peripheral slot |
| s_write | output | 1 | Forwarded access is a write |
| s_id | output | 6 | Target peripheral ID |
| s_offset | output | 8 | Register offset inside the peripheral |
| s_wdata | output | 32 | Forwarded write data |
| s_rdata | input | 32 | Read data from the selected peripheral |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Configuration register index |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data |
| irq_priv | output | 1 | Privilege-fault interrupt |
| irq_sec | output | 1 | Secure-path fault interrupt |

## Verification
The properties assume that reset is applied before the first request and that every master and configuration input is a known value at each clock edge. They also assume that the slot returns data in the same cycle that `s_valid` is high.

The stimulus pulses `m_req` for one cycle while `m_busy` is low. The one exception is a deliberate hold across the busy cycle, which checks that the request is ignored. Configuration writes are applied between accesses, except for the one cycle that deliberately overlaps a software clear with a hardware fault.

// File: rtl/pguard_pkg.sv
package pguard_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PASS = 2'd1,
        ST_DROP = 2'd2
    } gate_state_e;

    localparam int unsigned CFG_W     = 32;
    localparam int unsigned CFG_AW    = 4;
    localparam int unsigned FLAG_NUM  = 2;
    localparam int unsigned FB_PRIV   = 0;
    localparam int unsigned FB_SEC    = 1;

    localparam logic [CFG_AW-1:0] RA_CTRL    = 4'h0;
    localparam logic [CFG_AW-1:0] RA_PRIV_LO = 4'h1;
    localparam logic [CFG_AW-1:0] RA_PRIV_HI = 4'h2;
    localparam logic [CFG_AW-1:0] RA_SEC_LO  = 4'h3;
    localparam logic [CFG_AW-1:0] RA_SEC_HI  = 4'h4;
    localparam logic [CFG_AW-1:0] RA_FLAG    = 4'h5;
    localparam logic [CFG_AW-1:0] RA_FSET    = 4'h6;
    localparam logic [CFG_AW-1:0] RA_FCLR    = 4'h7;
    localparam logic [CFG_AW-1:0] RA_IEN     = 4'h8;
    localparam logic [CFG_AW-1:0] RA_ISET    = 4'h9;
    localparam logic [CFG_AW-1:0] RA_ICLR    = 4'hA;
    localparam logic [CFG_AW-1:0] RA_PEND    = 4'hB;
    localparam logic [CFG_AW-1:0] RA_FID     = 4'hC;

endpackage

// File: rtl/pguard_rules.sv
module pguard_rules #(
    parameter int unsigned ID_W    = 6,
    parameter int unsigned NPERIPH = 50
) (
    input  logic               enable,
    input  logic [NPERIPH-1:0] priv_attr,
    input  logic [NPERIPH-1:0] sec_attr,
    input  logic [ID_W-1:0]    req_id,
    input  logic               req_priv,
    input  logic               req_sec_path,
    output logic               priv_viol,
    output logic               sec_viol
);

    localparam int unsigned SPAN = 1 << ID_W;

    logic [SPAN-1:0] priv_ext;
    logic [SPAN-1:0] sec_ext;
    logic            need_priv;
    logic            is_secure;

    // IDs beyond the populated range behave as unprotected
    assign priv_ext  = SPAN'(priv_attr);
    assign sec_ext   = SPAN'(sec_attr);
    assign need_priv = priv_ext[req_id];
    assign is_secure = sec_ext[req_id];

    always_comb begin
        priv_viol = enable & need_priv & ~req_priv;
        sec_viol  = enable & (is_secure ^ req_sec_path);
    end

endmodule

// File: rtl/pguard_fsm.sv
module pguard_fsm
    import pguard_pkg::*;
#(
    parameter int unsigned DW    = 32,
    parameter int unsigned ID_W  = 6,
    parameter int unsigned OFS_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             m_req,
    input  logic             m_write,
    input  logic [ID_W-1:0]  req_id,
    input  logic [OFS_W-1:0] req_ofs,
    input  logic [DW-1:0]    m_wdata,
    input  logic             priv_viol,
    input  logic             sec_viol,
    input  logic [DW-1:0]    s_rdata,
    output logic             m_busy,
    output logic             m_done,
    output logic [DW-1:0]    m_rdata,
    output logic             s_valid,
    output logic             s_write,
    output logic [ID_W-1:0]  s_id,
    output logic [OFS_W-1:0] s_offset,
    output logic [DW-1:0]    s_wdata,
    output logic             hw_priv_fault,
    output logic             hw_sec_fault,
    output logic [ID_W-1:0]  fault_id
);

    gate_state_e state_q, state_d;

    logic             wr_q;
    logic [ID_W-1:0]  id_q;
    logic [OFS_W-1:0] ofs_q;
    logic [DW-1:0]    wdata_q;
    logic             pv_q;
    logic             sv_q;
    logic             accept;

    assign accept = (state_q == ST_IDLE) && m_req;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // transitions
    always_comb begin
        state_d = ST_IDLE;
        unique case (state_q)
            ST_IDLE: begin
                if (m_req) begin
                    state_d = (priv_viol || sec_viol) ? ST_DROP : ST_PASS;
                end
            end
            ST_PASS: state_d = ST_IDLE;
            ST_DROP: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // request capture and verdict, taken on acceptance
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q    <= 1'b0;
            id_q    <= '0;
            ofs_q   <= '0;
            wdata_q <= '0;
            pv_q    <= 1'b0;
            sv_q    <= 1'b0;
        end else if (accept) begin
            wr_q    <= m_write;
            id_q    <= req_id;
            ofs_q   <= req_ofs;
            wdata_q <= m_wdata;
            pv_q    <= priv_viol;
            sv_q    <= sec_viol;
        end
    end

    // outputs
    always_comb begin
        m_busy        = 1'b0;
        m_done        = 1'b0;
        m_rdata       = '0;
        s_valid       = 1'b0;
        s_write       = 1'b0;
        s_id          = '0;
        s_offset      = '0;
        s_wdata       = '0;
        hw_priv_fault = 1'b0;
        hw_sec_fault  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_PASS: begin
                m_busy   = 1'b1;
                m_done   = 1'b1;
                s_valid  = 1'b1;
                s_write  = wr_q;
                s_id     = id_q;
                s_offset = ofs_q;
                s_wdata  = wr_q ? wdata_q : '0;
                m_rdata  = wr_q ? '0 : s_rdata;
            end
            ST_DROP: begin
                m_busy        = 1'b1;
                m_done        = 1'b1;
                hw_priv_fault = pv_q;
                hw_sec_fault  = sv_q;
            end
            default: begin
            end
        endcase
    end

    assign fault_id = id_q;

endmodule

// File: rtl/pguard_regs.sv
module pguard_regs
    import pguard_pkg::*;
#(
    parameter int unsigned ID_W    = 6,
    parameter int unsigned NPERIPH = 50
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [CFG_AW-1:0]   cfg_addr,
    input  logic [CFG_W-1:0]    cfg_wdata,
    output logic [CFG_W-1:0]    cfg_rdata,
    input  logic                hw_priv_fault,
    input  logic                hw_sec_fault,
    input  logic [ID_W-1:0]     fault_id_in,
    output logic                en_q,
    output logic [NPERIPH-1:0]  priv_attr,
    output logic [NPERIPH-1:0]  sec_attr,
    output logic [FLAG_NUM-1:0] flag_q,
    output logic [FLAG_NUM-1:0] ien_q,
    output logic [ID_W-1:0]     fault_id_q,
    output logic                irq_priv,
    output logic                irq_sec
);

    localparam int unsigned ATTR_SPAN = 2 * CFG_W;

    logic [FLAG_NUM-1:0] hw_set;
    logic [FLAG_NUM-1:0] sw_set;
    logic [FLAG_NUM-1:0] sw_clr;
    logic [FLAG_NUM-1:0] flag_d;
    logic [ATTR_SPAN-1:0] priv_ext;
    logic [ATTR_SPAN-1:0] sec_ext;

    // one storage bit per peripheral and attribute
    for (genvar g = 0; g < NPERIPH; g++) begin : g_attr
        localparam int unsigned WORD = g / CFG_W;
        localparam int unsigned BITX = g % CFG_W;
        localparam logic [CFG_AW-1:0] PA = (WORD == 0) ? RA_PRIV_LO : RA_PRIV_HI;
        localparam logic [CFG_AW-1:0] SA = (WORD == 0) ? RA_SEC_LO  : RA_SEC_HI;
        logic p_bit;
        logic s_bit;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                p_bit <= 1'b0;
                s_bit <= 1'b0;
            end else if (cfg_we) begin
                if (cfg_addr == PA) p_bit <= cfg_wdata[BITX];
                if (cfg_addr == SA) s_bit <= cfg_wdata[BITX];
            end
        end
        assign priv_attr[g] = p_bit;
        assign sec_attr[g]  = s_bit;
    end

    assign priv_ext = ATTR_SPAN'(priv_attr);
    assign sec_ext  = ATTR_SPAN'(sec_attr);

    always_comb begin
        hw_set = '0;
        hw_set[FB_PRIV] = hw_priv_fault;
        hw_set[FB_SEC]  = hw_sec_fault;
        sw_set = (cfg_we && cfg_addr == RA_FSET) ? cfg_wdata[FLAG_NUM-1:0] : '0;
        sw_clr = (cfg_we && cfg_addr == RA_FCLR) ? cfg_wdata[FLAG_NUM-1:0] : '0;
        // hardware set takes priority over a simultaneous clear
        flag_d = (flag_q & ~sw_clr) | sw_set | hw_set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q       <= 1'b0;
            flag_q     <= '0;
            ien_q      <= '0;
            fault_id_q <= '0;
        end else begin
            flag_q <= flag_d;
            if (cfg_we && cfg_addr == RA_CTRL) en_q <= cfg_wdata[0];
            if (cfg_we && cfg_addr == RA_ISET) ien_q <= ien_q | cfg_wdata[FLAG_NUM-1:0];
            if (cfg_we && cfg_addr == RA_ICLR) ien_q <= ien_q & ~cfg_wdata[FLAG_NUM-1:0];
            if ((hw_priv_fault || hw_sec_fault) && (flag_q == '0)) begin
                fault_id_q <= fault_id_in;
            end
        end
    end

    always_comb begin
        case (cfg_addr)
            RA_CTRL:    cfg_rdata = CFG_W'(en_q);
            RA_PRIV_LO: cfg_rdata = priv_ext[CFG_W-1:0];
            RA_PRIV_HI: cfg_rdata = priv_ext[ATTR_SPAN-1:CFG_W];
            RA_SEC_LO:  cfg_rdata = sec_ext[CFG_W-1:0];
            RA_SEC_HI:  cfg_rdata = sec_ext[ATTR_SPAN-1:CFG_W];
            RA_FLAG:    cfg_rdata = CFG_W'(flag_q);
            RA_IEN:     cfg_rdata = CFG_W'(ien_q);
            RA_PEND:    cfg_rdata = CFG_W'(flag_q & ien_q);
            RA_FID:     cfg_rdata = CFG_W'(fault_id_q);
            default:    cfg_rdata = '0;
        endcase
    end

    assign irq_priv = flag_q[FB_PRIV] & ien_q[FB_PRIV];
    assign irq_sec  = flag_q[FB_SEC]  & ien_q[FB_SEC];

endmodule

// File: rtl/periph_guard.sv
module periph_guard
    import pguard_pkg::*;
#(
    parameter int unsigned DW      = 32,
    parameter int unsigned ID_W    = 6,
    parameter int unsigned OFS_W   = 8,
    parameter int unsigned NPERIPH = 50,
    localparam int unsigned ADDR_W = 1 + ID_W + OFS_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              m_req,
    input  logic              m_write,
    input  logic              m_priv,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DW-1:0]     m_wdata,
    output logic              m_busy,
    output logic              m_done,
    output logic [DW-1:0]     m_rdata,
    output logic              s_valid,
    output logic              s_write,
    output logic [ID_W-1:0]   s_id,
    output logic [OFS_W-1:0]  s_offset,
    output logic [DW-1:0]     s_wdata,
    input  logic [DW-1:0]     s_rdata,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic [CFG_W-1:0]  cfg_wdata,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              irq_priv,
    output logic              irq_sec
);

    logic                req_sec_path;
    logic [ID_W-1:0]     req_id;
    logic [OFS_W-1:0]    req_ofs;
    logic                priv_viol;
    logic                sec_viol;
    logic                en_q;
    logic [NPERIPH-1:0]  priv_attr;
    logic [NPERIPH-1:0]  sec_attr;
    logic [FLAG_NUM-1:0] flag_q;
    logic [FLAG_NUM-1:0] ien_q;
    logic [ID_W-1:0]     fault_id_q;
    logic                hw_priv_fault;
    logic                hw_sec_fault;
    logic [ID_W-1:0]     drop_id;

    assign req_sec_path = m_addr[ADDR_W-1];
    assign req_id       = m_addr[OFS_W +: ID_W];
    assign req_ofs      = m_addr[OFS_W-1:0];

    pguard_rules #(
        .ID_W    (ID_W),
        .NPERIPH (NPERIPH)
    ) u_rules (
        .enable       (en_q),
        .priv_attr    (priv_attr),
        .sec_attr     (sec_attr),
        .req_id       (req_id),
        .req_priv     (m_priv),
        .req_sec_path (req_sec_path),
        .priv_viol    (priv_viol),
        .sec_viol     (sec_viol)
    );

    pguard_fsm #(
        .DW    (DW),
        .ID_W  (ID_W),
        .OFS_W (OFS_W)
    ) u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .m_req         (m_req),
        .m_write       (m_write),
        .req_id        (req_id),
        .req_ofs       (req_ofs),
        .m_wdata       (m_wdata),
        .priv_viol     (priv_viol),
        .sec_viol      (sec_viol),
        .s_rdata       (s_rdata),
        .m_busy        (m_busy),
        .m_done        (m_done),
        .m_rdata       (m_rdata),
        .s_valid       (s_valid),
        .s_write       (s_write),
        .s_id          (s_id),
        .s_offset      (s_offset),
        .s_wdata       (s_wdata),
        .hw_priv_fault (hw_priv_fault),
        .hw_sec_fault  (hw_sec_fault),
        .fault_id      (drop_id)
    );

    pguard_regs #(
        .ID_W    (ID_W),
        .NPERIPH (NPERIPH)
    ) u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_we        (cfg_we),
        .cfg_addr      (cfg_addr),
        .cfg_wdata     (cfg_wdata),
        .cfg_rdata     (cfg_rdata),
        .hw_priv_fault (hw_priv_fault),
        .hw_sec_fault  (hw_sec_fault),
        .fault_id_in   (drop_id),
        .en_q          (en_q),
        .priv_attr     (priv_attr),
        .sec_attr      (sec_attr),
        .flag_q        (flag_q),
        .ien_q         (ien_q),
        .fault_id_q    (fault_id_q),
        .irq_priv      (irq_priv),
        .irq_sec       (irq_sec)
    );

endmodule

// File: rtl/pguard_sva.sv
module pguard_sva #(
    parameter int unsigned DW   = 32,
    parameter int unsigned ID_W = 6
) (
    input logic            clk,
    input logic            rst_n,
    input logic            m_req,
    input logic            m_busy,
    input logic            m_done,
    input logic            s_valid,
    input logic [DW-1:0]   m_rdata,
    input logic            en_q,
    input logic [1:0]      flag_q,
    input logic [ID_W-1:0] fault_id_q,
    input logic            hw_priv_fault,
    input logic            hw_sec_fault
);

    a_r11_done_next: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_busy) |=> m_done);

    a_r11_single_done: assert property (@(posedge clk) disable iff (!rst_n)
        m_done |=> !m_done);

    a_r3_blocked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (m_done && !s_valid) |-> (m_rdata == '0));

    a_r3_fault_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_priv_fault || hw_sec_fault) |-> !s_valid);

    a_r2_open_forward: assert property (@(posedge clk) disable iff (!rst_n)
        (m_req && !m_busy && !en_q) |=> s_valid);

    a_r4_priv_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hw_priv_fault |=> flag_q[0]);

    a_r5_sec_flag: assert property (@(posedge clk) disable iff (!rst_n)
        hw_sec_fault |=> flag_q[1]);

    a_r6_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q != 2'b00) |=> $stable(fault_id_q));

endmodule

bind periph_guard pguard_sva #(
    .DW   (DW),
    .ID_W (ID_W)
) u_sva (
    .clk           (clk),
    .rst_n         (rst_n),
    .m_req         (m_req),
    .m_busy        (m_busy),
    .m_done        (m_done),
    .s_valid       (s_valid),
    .m_rdata       (m_rdata),
    .en_q          (en_q),
    .flag_q        (flag_q),
    .fault_id_q    (fault_id_q),
    .hw_priv_fault (hw_priv_fault),
    .hw_sec_fault  (hw_sec_fault)
);

// File: tb/sim_periph_guard.sv
module sim_periph_guard;

    localparam int DW = 32;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        m_req = 1'b0;
    logic        m_write = 1'b0;
    logic        m_priv = 1'b0;
    logic [14:0] m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic        m_busy, m_done;
    logic [31:0] m_rdata;
    logic        s_valid, s_write;
    logic [5:0]  s_id;
    logic [7:0]  s_offset;
    logic [31:0] s_wdata, s_rdata;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic        irq_priv, irq_sec;

    localparam logic [3:0] A_CTRL = 4'h0, A_PLO = 4'h1, A_PHI = 4'h2, A_SLO = 4'h3,
                           A_SHI = 4'h4, A_FLAG = 4'h5, A_FSET = 4'h6, A_FCLR = 4'h7,
                           A_IEN = 4'h8, A_ISET = 4'h9, A_ICLR = 4'hA, A_PEND = 4'hB,
                           A_FID = 4'hC;

    int nchk = 0;
    int nerr = 0;
    bit finished = 1'b0;

    typedef struct {
        bit          fwd;
        bit          wr;
        logic [5:0]  id;
        logic [7:0]  ofs;
        logic [31:0] wd;
        logic [31:0] rd;
        int          rq;
    } exp_t;

    exp_t sb_q[$];

    always #10 clk = ~clk;

    // slot model: read data derived from the selected id and offset
    assign s_rdata = {10'h2B5, s_id, 8'h00, s_offset};

    periph_guard u0 (
        .clk(clk), .rst_n(rst_n),
        .m_req(m_req), .m_write(m_write), .m_priv(m_priv), .m_addr(m_addr),
        .m_wdata(m_wdata), .m_busy(m_busy), .m_done(m_done), .m_rdata(m_rdata),
        .s_valid(s_valid), .s_write(s_write), .s_id(s_id), .s_offset(s_offset),
        .s_wdata(s_wdata), .s_rdata(s_rdata),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .cfg_rdata(cfg_rdata), .irq_priv(irq_priv), .irq_sec(irq_sec)
    );

    task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL R%0d actual %h expected %h", rq, act, exp);
        end
    endtask

    function automatic logic [31:0] pat(input int id, input int ofs);
        return {10'h2B5, 6'(id), 8'h00, 8'(ofs)};
    endfunction

    task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic cfg_rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        cfg_addr = a;
        #1 d = cfg_rdata;
    endtask

    task automatic rd_chk(input int rq, input logic [3:0] a, input logic [31:0] exp);
        logic [31:0] v;
        cfg_rd(a, v);
        chk(rq, v, exp);
    endtask

    // driver: issue one access and push the expected completion
    task automatic push_exp(input int rq, input bit wr, input int id, input int ofs,
                            input logic [31:0] wd, input bit fwd);
        exp_t e;
        e.fwd = fwd; e.wr = wr; e.id = 6'(id); e.ofs = 8'(ofs); e.wd = wd; e.rq = rq;
        e.rd = (fwd && !wr) ? pat(id, ofs) : 32'h0;
        sb_q.push_back(e);
    endtask

    task automatic access(input int rq, input bit wr, input bit pr, input bit sec,
                          input int id, input int ofs, input logic [31:0] wd, input bit fwd);
        @(negedge clk);
        m_req = 1'b1; m_write = wr; m_priv = pr;
        m_addr = {sec, 6'(id), 8'(ofs)}; m_wdata = wd;
        push_exp(rq, wr, id, ofs, wd, fwd);
        @(negedge clk);
        m_req = 1'b0;
        @(negedge clk);
    endtask

    // monitor: compare each completion with the head of the scoreboard
    always @(negedge clk) begin
        if (rst_n && m_done) begin
            if (sb_q.size() == 0) begin
                nchk++; nerr++;
                $display("FAIL R11 actual unexpected completion expected none");
            end else begin
                exp_t e;
                e = sb_q.pop_front();
                chk(e.rq, 32'(s_valid), 32'(e.fwd));
                chk(e.rq, m_rdata, e.rd);
                if (e.fwd) begin
                    chk(e.rq, 32'(s_id), 32'(e.id));
                    chk(e.rq, 32'(s_offset), 32'(e.ofs));
                    chk(e.rq, 32'(s_write), 32'(e.wr));
                    if (e.wr) chk(e.rq, s_wdata, e.wd);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            nchk++; nerr++;
            $display("FAIL R11 actual watchdog expired expected completion");
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_chk(1, A_CTRL, 32'h0);
        rd_chk(1, A_PLO, 32'h0);
        rd_chk(1, A_SHI, 32'h0);
        rd_chk(1, A_FLAG, 32'h0);
        rd_chk(1, A_IEN, 32'h0);
        rd_chk(1, A_FID, 32'h0);
        chk(1, {29'h0, irq_priv, irq_sec, m_busy}, 32'h0);

        // R2 protection off: everything passes
        cfg_wr(A_PLO, 32'h0000_0020);            // id 5 privileged-only
        rd_chk(7, A_PLO, 32'h0000_0020);          // R7 attribute readback
        access(2, 1'b0, 1'b0, 1'b0, 5, 8'h12, 32'h0, 1'b1);
        access(2, 1'b1, 1'b0, 1'b0, 5, 8'h34, 32'hCAFE_0001, 1'b1);
        access(2, 1'b0, 1'b1, 1'b1, 3, 8'h01, 32'h0, 1'b1);
        rd_chk(2, A_FLAG, 32'h0);

        // R3 and R4 privilege rule
        cfg_wr(A_CTRL, 32'h1);
        access(3, 1'b0, 1'b0, 1'b0, 5, 8'h20, 32'h0, 1'b0);
        rd_chk(4, A_FLAG, 32'h1);
        rd_chk(4, A_FID, 32'd5);
        access(3, 1'b0, 1'b1, 1'b0, 5, 8'h21, 32'h0, 1'b1);
        access(3, 1'b1, 1'b0, 1'b0, 5, 8'h22, 32'hDEAD_BEEF, 1'b0);

        // R6 first id held while a flag is pending
        cfg_wr(A_PHI, 32'h0000_0100);            // id 40
        access(6, 1'b0, 1'b0, 1'b0, 40, 8'h02, 32'h0, 1'b0);
        rd_chk(6, A_FID, 32'd5);
        cfg_wr(A_FCLR, 32'h3);
        rd_chk(7, A_FLAG, 32'h0);
        access(6, 1'b0, 1'b0, 1'b0, 40, 8'h03, 32'h0, 1'b0);
        rd_chk(6, A_FID, 32'd40);
        cfg_wr(A_FCLR, 32'h3);

        // R5 secure-path rule
        cfg_wr(A_SHI, 32'h0000_0002);            // id 33 secure
        access(5, 1'b0, 1'b1, 1'b0, 33, 8'h04, 32'h0, 1'b0);
        rd_chk(5, A_FLAG, 32'h2);
        rd_chk(5, A_FID, 32'd33);
        access(5, 1'b0, 1'b1, 1'b1, 33, 8'h05, 32'h0, 1'b1);
        access(5, 1'b1, 1'b1, 1'b1, 2, 8'h06, 32'h1234_5678, 1'b0);
        access(5, 1'b1, 1'b1, 1'b0, 2, 8'h07, 32'h1234_5678, 1'b1);
        rd_chk(6, A_FID, 32'd33);
        cfg_wr(A_FCLR, 32'h3);

        // R7, R8, R9 software flags, enables, pending, interrupts
        cfg_wr(A_FSET, 32'h2);
        rd_chk(7, A_FLAG, 32'h2);
        chk(9, 32'(irq_sec), 32'h0);
        cfg_wr(A_ISET, 32'h2);
        chk(9, 32'(irq_sec), 32'h1);
        rd_chk(7, A_IEN, 32'h2);
        rd_chk(8, A_PEND, 32'h2);
        cfg_wr(A_FSET, 32'h1);
        rd_chk(8, A_PEND, 32'h2);
        rd_chk(8, A_FLAG, 32'h3);
        rd_chk(8, A_FLAG, 32'h3);
        chk(9, 32'(irq_priv), 32'h0);
        cfg_wr(A_ISET, 32'h1);
        chk(9, 32'(irq_priv), 32'h1);
        cfg_wr(A_ICLR, 32'h2);
        rd_chk(7, A_IEN, 32'h1);
        chk(9, 32'(irq_sec), 32'h0);
        cfg_wr(A_FCLR, 32'h3);
        chk(9, 32'(irq_priv), 32'h0);
        rd_chk(7, A_FLAG, 32'h0);

        // R10 hardware fault beats a same-cycle software clear
        @(negedge clk);
        m_req = 1'b1; m_write = 1'b0; m_priv = 1'b0; m_addr = {1'b0, 6'd5, 8'h09};
        push_exp(10, 1'b0, 5, 8'h09, 32'h0, 1'b0);
        @(negedge clk);
        m_req = 1'b0;
        cfg_we = 1'b1; cfg_addr = A_FCLR; cfg_wdata = 32'h1;
        @(negedge clk);
        cfg_we = 1'b0;
        rd_chk(10, A_FLAG, 32'h1);
        rd_chk(10, A_FID, 32'd5);

        // R11 request while busy is ignored
        @(negedge clk);
        m_req = 1'b1; m_write = 1'b1; m_priv = 1'b1; m_addr = {1'b0, 6'd7, 8'h0A};
        m_wdata = 32'h0BAD_F00D;
        push_exp(11, 1'b1, 7, 8'h0A, 32'h0BAD_F00D, 1'b1);
        @(negedge clk);
        chk(11, 32'(m_busy), 32'h1);
        m_addr = {1'b0, 6'd9, 8'h0B};
        @(negedge clk);
        m_req = 1'b0;
        chk(11, 32'(m_done), 32'h0);

        repeat (4) @(negedge clk);
        chk(11, 32'(sb_q.size()), 32'h0);

        finished = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

endmodule